// File: doc/BRIEF.md
# Path-Addressed Wormhole Packet Switch

This block joins the character-level receive and transmit queues of several link ports and moves packets between them. Each port presents a receive side (empty flag, read strobe, control flag, 8-bit character) and a transmit side (full flag, write strobe, control flag, 8-bit character). A control flag of 1 marks a control character. With the flag set, value 0x00 is a normal end-of-packet and value 0x01 is an error end-of-packet.

When a port has a character waiting and the switch is idle, a round-robin arbiter picks that port. The switch reads the packet's first character as a path address. This value is the number of the output port, and the switch drops it. It then opens one connection from the chosen input to the chosen output. Characters pass one per cycle as they arrive and as the output can take them, so the packet is never stored whole. The connection closes on either end marker. Only one connection exists at a time. A packet whose path address names no existing port is read and thrown away.

Top module: `pw_switch`

## Requirements
- R1: After reset, with all receive sides empty, no read strobe and no write strobe is asserted. The arbiter starts its search at port 0.
- R2: The first data character (flag 0) of a packet selects the output port by its value (0 to NPORTS-1). This character is consumed and never written to any output.
- R3: In a connection, one character moves in a cycle exactly when the source is not empty and the destination is not full. Its read strobe and write strobe are both high in that cycle, and the flag and value pass through unchanged and in order.
- R4: A control character with value 0x00 (end-of-packet) is forwarded and closes the connection. The next cycle treats a new character as a path address.
- R5: A control character with value 0x01 (error end-of-packet) is forwarded and closes the connection in the same way.
- R6: A control character with any other value inside a packet is forwarded and does not close the connection.
- R7: A path address of NPORTS or more makes the switch read and discard the packet through its end marker, with no write strobe during that time.
- R8: At most one read strobe and at most one write strobe are high in any cycle. While a connection is open, no other input is read.
- R9: Among waiting inputs, the arbiter grants the first one found starting from the port after the last granted port, wrapping around.
- R10: A control character that arrives where a path address is expected is read and discarded, and the switch stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_empty | input | NPORTS | Receive queue empty, one bit per port |
| rx_rd | output | NPORTS | Receive read strobe, one bit per port |
| rx_ctrl | input | NPORTS | Control flag of the character at the receive head |
| rx_data | input | NPORTS*DW | Receive head characters, port p at bits p*DW +: DW |
| tx_full | input | NPORTS | Transmit queue full, one bit per port |
| tx_wr | output | NPORTS | Transmit write strobe, one bit per port |
| tx_ctrl | output | NPORTS | Control flag of the written character |
| tx_data | output | NPORTS*DW | Written characters, port p at bits p*DW +: DW |

## Verification
The bench uses the default build of three ports with 8-bit characters. At this size, path addresses 0 to 2 are valid and a value of 7 is out of range, and the arbiter pointer wraps from port 2 back to port 0 within a few packets. A pseudo-random pattern raises full flags on the outputs and hides characters at the inputs in the middle of packets. With all three ports loaded at once, the grant order and the one-connection rule are compared cycle by cycle against the bench's own model.

// File: rtl/pws_pkg.sv
`timescale 1ns/1ps
package pws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_DROP = 2'd2
  } sw_state_e;

  localparam int EOP_CODE = 0;
  localparam int EEP_CODE = 1;

endpackage

// File: rtl/pws_rr_arb.sv
`timescale 1ns/1ps
module pws_rr_arb #(
  parameter int N  = 3,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          gnt_vld,
  output logic [PW-1:0] gnt_idx
);

  logic [PW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  // search from ptr_q upward, wrapping; the lowest offset wins
  always_comb begin
    int t;
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int off = N - 1; off >= 0; off--) begin
      t = int'(ptr_q) + off;
      if (t >= N) t = t - N;
      if (req[t]) begin
        gnt_vld = 1'b1;
        gnt_idx = PW'(t);
      end
    end
  end

  always_comb begin
    ptr_en = adv && gnt_vld;
    ptr_d  = ptr_q;
    if (ptr_en) begin
      if (int'(gnt_idx) == N - 1) ptr_d = '0;
      else                        ptr_d = gnt_idx + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R9
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> req[gnt_idx]);

  // R9
  ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && gnt_vld) |=> (ptr_q != $past(gnt_idx)));

endmodule

// File: rtl/pws_xbar.sv
`timescale 1ns/1ps
module pws_xbar #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int PW = 2
) (
  input  logic [PW-1:0]   rd_port,
  input  logic [PW-1:0]   wr_port,
  input  logic            rd_go,
  input  logic            wr_go,
  input  logic [N-1:0]    rx_empty,
  input  logic [N-1:0]    rx_ctrl,
  input  logic [N*DW-1:0] rx_data,
  input  logic [N-1:0]    tx_full,
  output logic [N-1:0]    rx_rd,
  output logic [N-1:0]    tx_wr,
  output logic [N-1:0]    tx_ctrl,
  output logic [N*DW-1:0] tx_data,
  output logic            sel_empty,
  output logic            sel_full,
  output logic            sel_ctrl,
  output logic [DW-1:0]   sel_data
);

  // input side: one selected source
  always_comb begin
    sel_empty = 1'b1;
    sel_ctrl  = 1'b0;
    sel_data  = '0;
    sel_full  = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (rd_port == PW'(i)) begin
        sel_empty = rx_empty[i];
        sel_ctrl  = rx_ctrl[i];
        sel_data  = rx_data[i*DW +: DW];
      end
      if (wr_port == PW'(i)) sel_full = tx_full[i];
    end
  end

  // per-port strobes and output steering
  for (genvar g = 0; g < N; g++) begin : g_port
    assign rx_rd[g]              = rd_go && (rd_port == PW'(g));
    assign tx_wr[g]              = wr_go && (wr_port == PW'(g));
    assign tx_ctrl[g]            = (wr_port == PW'(g)) && sel_ctrl;
    assign tx_data[g*DW +: DW]   = (wr_port == PW'(g)) ? sel_data : '0;
  end

endmodule

// File: rtl/pws_ctrl.sv
`timescale 1ns/1ps
module pws_ctrl
  import pws_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gnt_vld,
  input  logic [PW-1:0] gnt_idx,
  input  logic          sel_empty,
  input  logic          sel_full,
  input  logic          sel_ctrl,
  input  logic [DW-1:0] sel_data,
  output logic [PW-1:0] rd_port,
  output logic [PW-1:0] wr_port,
  output logic          rd_go,
  output logic          wr_go,
  output logic          adv
);

  sw_state_e     st_q, st_d;
  logic [PW-1:0] src_q, dst_q;
  logic          src_en, dst_en;
  logic          is_end;

  assign is_end  = sel_ctrl && ((sel_data == DW'(EOP_CODE)) || (sel_data == DW'(EEP_CODE)));
  assign wr_port = dst_q;

  always_comb begin
    st_d    = st_q;
    src_en  = 1'b0;
    dst_en  = 1'b0;
    rd_go   = 1'b0;
    wr_go   = 1'b0;
    adv     = 1'b0;
    rd_port = src_q;
    case (st_q)
      ST_IDLE: begin
        rd_port = gnt_idx;
        if (gnt_vld) begin
          rd_go = 1'b1;
          adv   = 1'b1;
          if (!sel_ctrl) begin
            src_en = 1'b1;
            if (sel_data < DW'(N)) begin
              dst_en = 1'b1;
              st_d   = ST_FWD;
            end else begin
              st_d   = ST_DROP;
            end
          end
        end
      end
      ST_FWD: begin
        if (!sel_empty && !sel_full) begin
          rd_go = 1'b1;
          wr_go = 1'b1;
          if (is_end) st_d = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (!sel_empty) begin
          rd_go = 1'b1;
          if (is_end) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      src_q <= '0;
      dst_q <= '0;
    end else begin
      st_q <= st_d;
      if (src_en) src_q <= gnt_idx;
      if (dst_en) dst_q <= sel_data[PW-1:0];
    end
  end

  // R7
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP) |-> !wr_go);

  // R4 R5
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && sel_ctrl && (sel_data <= DW'(EEP_CODE))) |=> (st_q == ST_IDLE));

  // R6
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && sel_ctrl && (sel_data > DW'(EEP_CODE))) |=> (st_q == ST_FWD));

endmodule

// File: rtl/pw_switch.sv
`timescale 1ns/1ps
module pw_switch #(
  parameter int NPORTS = 3,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    rx_empty,
  output logic [NPORTS-1:0]    rx_rd,
  input  logic [NPORTS-1:0]    rx_ctrl,
  input  logic [NPORTS*DW-1:0] rx_data,
  input  logic [NPORTS-1:0]    tx_full,
  output logic [NPORTS-1:0]    tx_wr,
  output logic [NPORTS-1:0]    tx_ctrl,
  output logic [NPORTS*DW-1:0] tx_data
);

  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic          gnt_vld, adv;
  logic [PW-1:0] gnt_idx, rd_port, wr_port;
  logic          rd_go, wr_go;
  logic          sel_empty, sel_full, sel_ctrl;
  logic [DW-1:0] sel_data;

  pws_rr_arb #(.N(NPORTS), .PW(PW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (~rx_empty),
    .adv     (adv),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  pws_ctrl #(.N(NPORTS), .DW(DW), .PW(PW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_vld   (gnt_vld),
    .gnt_idx   (gnt_idx),
    .sel_empty (sel_empty),
    .sel_full  (sel_full),
    .sel_ctrl  (sel_ctrl),
    .sel_data  (sel_data),
    .rd_port   (rd_port),
    .wr_port   (wr_port),
    .rd_go     (rd_go),
    .wr_go     (wr_go),
    .adv       (adv)
  );

  pws_xbar #(.N(NPORTS), .DW(DW), .PW(PW)) u_xbar (
    .rd_port   (rd_port),
    .wr_port   (wr_port),
    .rd_go     (rd_go),
    .wr_go     (wr_go),
    .rx_empty  (rx_empty),
    .rx_ctrl   (rx_ctrl),
    .rx_data   (rx_data),
    .tx_full   (tx_full),
    .rx_rd     (rx_rd),
    .tx_wr     (tx_wr),
    .tx_ctrl   (tx_ctrl),
    .tx_data   (tx_data),
    .sel_empty (sel_empty),
    .sel_full  (sel_full),
    .sel_ctrl  (sel_ctrl),
    .sel_data  (sel_data)
  );

  // R8
  one_reader_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_rd));

  // R8
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_wr));

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd & rx_empty) == '0);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr & tx_full) == '0);

  // R3
  paired_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr != '0) |-> (rx_rd != '0));

endmodule

// File: tb/pw_switch_tb.sv
`timescale 1ns/1ps
module pw_switch_tb;

  localparam int NP = 3;
  localparam int DW = 8;
  localparam logic [8:0] EOP = 9'h100;
  localparam logic [8:0] EEP = 9'h101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0]    rx_empty = '1;
  logic [NP-1:0]    rx_rd;
  logic [NP-1:0]    rx_ctrl  = '0;
  logic [NP*DW-1:0] rx_data  = '0;
  logic [NP-1:0]    tx_full  = '0;
  logic [NP-1:0]    tx_wr;
  logic [NP-1:0]    tx_ctrl;
  logic [NP*DW-1:0] tx_data;

  pw_switch #(.NPORTS(NP), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_empty(rx_empty), .rx_rd(rx_rd), .rx_ctrl(rx_ctrl), .rx_data(rx_data),
    .tx_full(tx_full), .tx_wr(tx_wr), .tx_ctrl(tx_ctrl), .tx_data(tx_data)
  );

  logic [8:0] rxq [NP][$];
  logic [8:0] txq [NP][$];
  logic [8:0] exq [$];

  int checks = 0;
  int errors = 0;
  int mstate = 0;   // 0 idle, 1 forwarding, 2 discarding
  int msrc = 0;
  int mdst = 0;
  int mptr = 0;
  logic        stress = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_end(input logic [8:0] v);
    return v == EOP || v == EEP;
  endfunction

  task automatic step();
    logic [NP-1:0] e, erd, ewr;
    logic [8:0]    v;
    bit            found;
    int            k;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int p = 0; p < NP; p++) begin
      e[p]       = (rxq[p].size() == 0) || (stress && lfsr[p] && lfsr[p+4]);
      tx_full[p] = stress && lfsr[p+8];
      rx_empty[p] = e[p];
      rx_ctrl[p]  = e[p] ? 1'b0 : rxq[p][0][8];
      rx_data[p*DW +: DW] = e[p] ? 8'h00 : rxq[p][0][7:0];
    end
    #1;
    erd = '0; ewr = '0; v = '0; found = 1'b0; k = 0;
    case (mstate)
      0: begin
        for (int off = 0; off < NP; off++) begin
          if (!found && !e[(mptr + off) % NP]) begin
            found = 1'b1;
            k = (mptr + off) % NP;
          end
        end
        if (found) begin
          erd[k] = 1'b1;
          v = rxq[k][0];
        end
      end
      1: if (!e[msrc] && !tx_full[mdst]) begin
        erd[msrc] = 1'b1; ewr[mdst] = 1'b1; v = rxq[msrc][0];
      end
      default: if (!e[msrc]) begin
        erd[msrc] = 1'b1; v = rxq[msrc][0];
      end
    endcase
    // R9 during arbitration, R3 while a connection is open
    check(rx_rd === erd, (mstate == 0) ? "R9" : "R3", "read strobes", int'(rx_rd), int'(erd));
    check(tx_wr === ewr, (mstate == 2) ? "R7" : "R3", "write strobes", int'(tx_wr), int'(ewr));
    if (ewr != '0)
      check({tx_ctrl[mdst], tx_data[mdst*DW +: DW]} === v, "R3", "written character",
            int'({tx_ctrl[mdst], tx_data[mdst*DW +: DW]}), int'(v));
    // R8
    check($countones(rx_rd) <= 1 && $countones(tx_wr) <= 1, "R8", "strobe count",
          int'({rx_rd, tx_wr}), 0);
    for (int p = 0; p < NP; p++) begin
      if (tx_wr[p]) txq[p].push_back({tx_ctrl[p], tx_data[p*DW +: DW]});
      if (erd[p]) void'(rxq[p].pop_front());
    end
    case (mstate)
      0: if (found) begin
        mptr = (k + 1) % NP;
        if (!v[8]) begin
          msrc = k;
          if (int'(v[7:0]) < NP) begin mdst = int'(v[7:0]); mstate = 1; end
          else mstate = 2;
        end
      end
      default: if (erd != '0 && is_end(v)) mstate = 0;
    endcase
  endtask

  task automatic run_idle();
    int c = 0;
    do begin
      step();
      c++;
    end while ((rxq[0].size() + rxq[1].size() + rxq[2].size() != 0 || mstate != 0) && c < 2000);
    repeat (3) step();
  endtask

  task automatic send(input int p, input logic [8:0] c);
    rxq[p].push_back(c);
  endtask

  task automatic expect_port(input int p, input string tag);
    check(txq[p].size() == exq.size(), tag, $sformatf("port %0d length", p),
          txq[p].size(), exq.size());
    for (int i = 0; i < exq.size() && i < txq[p].size(); i++)
      check(txq[p][i] === exq[i], tag, $sformatf("port %0d char %0d", p, i),
            int'(txq[p][i]), int'(exq[i]));
    exq.delete();
  endtask

  task automatic clear_tx();
    for (int p = 0; p < NP; p++) txq[p].delete();
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(rx_rd === '0, "R1", "read strobes after reset", int'(rx_rd), 0);
    check(tx_wr === '0, "R1", "write strobes after reset", int'(tx_wr), 0);
    repeat (2) step();

    // R2 R4: six characters in, header removed, five out on port 1
    send(0, 9'h001); send(0, 9'h0A1); send(0, 9'h0A2); send(0, 9'h0A3); send(0, 9'h0A4); send(0, EOP);
    run_idle();
    exq.push_back(9'h0A1); exq.push_back(9'h0A2); exq.push_back(9'h0A3); exq.push_back(9'h0A4);
    exq.push_back(EOP);
    expect_port(1, "R4");
    expect_port(0, "R2");
    expect_port(2, "R2");
    clear_tx();

    // R5 R3: error end then a normal packet, under backpressure and input gaps
    stress = 1'b1;
    send(2, 9'h000); for (int i = 0; i < 5; i++) send(2, 9'(9'h050 + i)); send(2, EEP);
    send(2, 9'h002); send(2, 9'h0B0); send(2, EOP);
    run_idle();
    for (int i = 0; i < 5; i++) exq.push_back(9'(9'h050 + i));
    exq.push_back(EEP);
    expect_port(0, "R5");
    exq.push_back(9'h0B0); exq.push_back(EOP);
    expect_port(2, "R5");
    clear_tx();

    // R6: other control character inside a packet
    send(1, 9'h002); send(1, 9'h010); send(1, 9'h105); send(1, 9'h011); send(1, EOP);
    run_idle();
    exq.push_back(9'h010); exq.push_back(9'h105); exq.push_back(9'h011); exq.push_back(EOP);
    expect_port(2, "R6");
    clear_tx();

    // R7: invalid path address 7 discarded, next packet delivered
    send(0, 9'h007); send(0, 9'h0C1); send(0, 9'h0C2); send(0, EOP);
    run_idle();
    expect_port(0, "R7"); expect_port(1, "R7"); expect_port(2, "R7");
    check(rxq[0].size() == 0, "R7", "discarded packet consumed", rxq[0].size(), 0);
    send(0, 9'h001); send(0, 9'h0C3); send(0, EOP);
    run_idle();
    exq.push_back(9'h0C3); exq.push_back(EOP);
    expect_port(1, "R7");
    clear_tx();

    // R10: stray end marker where a header is expected
    send(1, EOP); send(1, 9'h000); send(1, 9'h0D1); send(1, EOP);
    run_idle();
    exq.push_back(9'h0D1); exq.push_back(EOP);
    expect_port(0, "R10");
    expect_port(1, "R10");
    clear_tx();

    // R8 R9: all three inputs contend
    send(0, 9'h002); send(0, 9'h021); send(0, 9'h022); send(0, EOP);
    send(1, 9'h000); send(1, 9'h031); send(1, EOP);
    send(2, 9'h001); send(2, 9'h041); send(2, 9'h042); send(2, 9'h043); send(2, EEP);
    run_idle();
    exq.push_back(9'h021); exq.push_back(9'h022); exq.push_back(EOP);
    expect_port(2, "R8");
    exq.push_back(9'h031); exq.push_back(EOP);
    expect_port(0, "R8");
    exq.push_back(9'h041); exq.push_back(9'h042); exq.push_back(9'h043); exq.push_back(EEP);
    expect_port(1, "R9");
    clear_tx();

    // R9: two inputs to one output, order set by the pointer
    send(0, 9'h001); send(0, 9'h061); send(0, EOP);
    send(2, 9'h001); send(2, 9'h071); send(2, EOP);
    run_idle();
    check(txq[1].size() == 4, "R9", "shared output length", txq[1].size(), 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule